// File: doc/BRIEF.md
# Serial Character Receiver with Line and Modem Status

This block is an asynchronous serial receiver. A one-cycle tick input runs at sixteen times the bit rate. The receiver uses that tick to find a start bit and confirm it at mid-bit. It then samples 5 to 8 data bits, least significant bit first, an optional parity bit and one stop bit. Each finished character goes into a receive holding register.

Beside the data, the block keeps a set of status bits for a host to poll:

- a ready bit, which the data-read strobe clears;
- three sticky error bits for framing, parity and overrun, which only the one-shot error-clear pulse resets;
- the levels of two active-low modem status pins, DSR and DCD, shown inverted;
- a change flag that any movement on either modem pin sets, and the status-read strobe clears.

The receive enable controls the whole receive path. After enable rises, one tick passes before the search for a start bit begins, so the first line sample is taken on the second tick. Dropping enable stops reception at once, throws away a partly assembled character and empties the holding register. The serial line and the modem pins are synchronised to the clock inside the block. The format inputs must stay stable while a character is being received.

Top module: `uart_rx_status`

## Requirements
- R1: After `rx_en` rises, the first tick only arms the receiver, and the line is first sampled for a start bit on the second tick. A start bit is confirmed 8 ticks after it is detected.
- R2: While `rx_en` is low, `st_ready` reads 0 from the next clock on. A character partly received when `rx_en` falls is discarded and never delivered.
- R3: The number of data bits is `cfg_len` + 5 (code 0 gives 5 bits, code 3 gives 8 bits). They are received least significant bit first and are right-aligned in `rx_data` with the unused upper bits at 0.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. The parity is even when `cfg_par_odd` is 0 and odd when it is 1. A mismatch sets `st_parity_err`.
- R5: A low first stop bit sets `st_frame_err`, and the character is still delivered. The receiver then waits for the line to return high before it looks for the next start bit.
- R6: A character that finishes while `st_ready` is 1 and no data read is happening sets `st_overrun`. The new character replaces the old one.
- R7: `st_ready` is 0 after reset, goes to 1 when a character is stored, and returns to 0 one clock after a `rd_data` pulse.
- R8: `st_frame_err`, `st_parity_err` and `st_overrun` stay set until an `err_clr` pulse clears them. Reading the data does not clear them.
- R9: A low level on the line that is high again at the mid-bit confirmation sample is treated as noise. No character is produced, and the search for a start bit resumes.
- R10: `st_dsr` and `st_dcd` read 1 when `dsr_n` or `dcd_n` respectively is low, and 0 when it is high. Each follows its pin after a two-clock synchroniser.
- R11: `st_dschg` is set by any change of the synchronised `dsr_n` or `dcd_n`. It is cleared by a `rd_status` pulse, and a change in the same cycle as the pulse takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| err_clr | input | 1 | One-shot pulse that clears the three error flags |
| rd_data | input | 1 | Holding-register read strobe |
| rd_status | input | 1 | Status read strobe, clears the change flag |
| cfg_len | input | 2 | Data length code, giving `cfg_len` + 5 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| rx_data | output | 8 | Receive holding register |
| st_ready | output | 1 | Holding register holds an unread character |
| st_frame_err | output | 1 | Sticky framing error |
| st_parity_err | output | 1 | Sticky parity error |
| st_overrun | output | 1 | Sticky overrun |
| st_dsr | output | 1 | Inverted level of `dsr_n` |
| st_dcd | output | 1 | Inverted level of `dcd_n` |
| st_dschg | output | 1 | Modem status change flag |

## Verification
A wrong bit counter or a wrong sampling phase shows up in `rx_data` or in a false parity error one character time later, about 160 ticks. A wrong arming count or a wrong mid-bit check shows up as a character that should not appear, within one character time of the noise pulse placed around the confirmation sample. A mistake in the sticky flags or the ready handshake shows at the next status sample, a single clock after the strobe or the delivery that should have changed them. A polarity fault on the modem inputs shows within three clocks of the pin change.

// File: rtl/rx_pkg.sv
// Package: shared types for the serial character receiver.
// Assumes: one stop bit, format inputs stable while a character is received.
package rx_pkg;

    // Receiver sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

endpackage

// File: rtl/rx_sync_bits.sv
// Module: multi-stage flop synchroniser for slow asynchronous level inputs.
// Assumes: inputs are levels held much longer than STAGES clocks.
module rx_sync_bits #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RESET_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Later stages shift the captured value along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RESET_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/rx_bit_framer.sv
// Module: start-bit search, oversampled bit timing and character assembly.
// Assumes: rxd already synchronised; rx_tick is a one-cycle pulse at
// OVERSAMPLE times the bit rate; DATA_W = MIN_BITS + 3 (2-bit length code).
module rx_bit_framer
    import rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MIN_BITS   = 5,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_tick,
    input  logic              rxd_s,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic              chr_done,
    output logic [DATA_W-1:0] chr_data,
    output logic              chr_fe,
    output logic              chr_pe
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVERSAMPLE - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              par_bad;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  shamt;
    logic              bit_edge;

    // Index of the final data bit and right-alignment shift for the length
    always_comb begin
        last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
        shamt    = IDX_W'(DATA_W - MIN_BITS) - IDX_W'(cfg_len);
        bit_edge = rx_tick && (cnt == FULL_CNT);
    end

    // Sequencer: arming, hunting, confirmation, bit sampling and delivery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            chr_done <= 1'b0;
            chr_data <= '0;
            chr_fe   <= 1'b0;
            chr_pe   <= 1'b0;
        end else begin
            chr_done <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_IDLE: state <= ST_ARM;
                    ST_ARM: begin
                        if (rx_tick) state <= ST_HUNT;
                    end
                    ST_HUNT: begin
                        if (rx_tick && !rxd_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (rx_tick) begin
                            if (cnt == MID_CNT) begin
                                cnt <= '0;
                                if (rxd_s) begin
                                    state <= ST_HUNT;
                                end else begin
                                    state   <= ST_DATA;
                                    bit_idx <= '0;
                                    shreg   <= '0;
                                    par_acc <= 1'b0;
                                    par_bad <= 1'b0;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (bit_edge) begin
                            cnt     <= '0;
                            shreg   <= {rxd_s, shreg[DATA_W-1:1]};
                            par_acc <= par_acc ^ rxd_s;
                            if (bit_idx == last_idx)
                                state <= cfg_par_en ? ST_PAR : ST_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else if (rx_tick) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (bit_edge) begin
                            cnt     <= '0;
                            par_bad <= par_acc ^ rxd_s ^ cfg_par_odd;
                            state   <= ST_STOP;
                        end else if (rx_tick) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (bit_edge) begin
                            cnt      <= '0;
                            chr_done <= 1'b1;
                            chr_data <= shreg >> shamt;
                            chr_fe   <= !rxd_s;
                            chr_pe   <= cfg_par_en && par_bad;
                            state    <= rxd_s ? ST_HUNT : ST_WAITHI;
                        end else if (rx_tick) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAITHI: begin
                        if (rx_tick && rxd_s) state <= ST_HUNT;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_hold_status.sv
// Module: receive holding register with ready, framing, parity, overrun flags.
// Assumes: chr_done is a one-cycle pulse from the framer.
module rx_hold_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              chr_done,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_fe,
    input  logic              chr_pe,
    input  logic              rd_data,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              st_ready,
    output logic              st_frame_err,
    output logic              st_parity_err,
    output logic              st_overrun
);

    logic accept;

    // A character counts only while the receiver is enabled
    always_comb accept = chr_done && rx_en;

    // Holding register and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            st_ready <= 1'b0;
        end else begin
            if (accept) rx_data <= chr_data;
            if (!rx_en)        st_ready <= 1'b0;
            else if (accept)   st_ready <= 1'b1;
            else if (rd_data)  st_ready <= 1'b0;
        end
    end

    // Sticky error flags, new events win over the clear pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_frame_err  <= 1'b0;
            st_parity_err <= 1'b0;
            st_overrun    <= 1'b0;
        end else begin
            if (accept && chr_fe)      st_frame_err <= 1'b1;
            else if (err_clr)          st_frame_err <= 1'b0;
            if (accept && chr_pe)      st_parity_err <= 1'b1;
            else if (err_clr)          st_parity_err <= 1'b0;
            if (accept && st_ready && !rd_data) st_overrun <= 1'b1;
            else if (err_clr)          st_overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_modem_watch.sv
// Module: modem status pin synchronisation, polarity and change detection.
// Assumes: pins are active-low levels; reset takes them as inactive (high).
module rx_modem_watch #(
    parameter int PINS        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_n,
    input  logic            rd_status,
    output logic [PINS-1:0] active,
    output logic            changed
);

    logic [PINS-1:0] pin_s;
    logic [PINS-1:0] pin_q;

    rx_sync_bits #(
        .WIDTH     (PINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({PINS{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_n),
        .q     (pin_s)
    );

    // Pins are low-active, so status reads their complement
    always_comb active = ~pin_s;

    // Remember last synchronised level and flag any difference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= '1;
            changed <= 1'b0;
        end else begin
            pin_q <= pin_s;
            if (pin_s != pin_q) changed <= 1'b1;
            else if (rd_status) changed <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
// Module: top of the serial character receiver with status flags.
// Assumes: rx_tick runs at 16x bit rate; format inputs held steady per char.
module uart_rx_status #(
    parameter int DATA_W      = 8,
    parameter int MIN_BITS    = 5,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              err_clr,
    input  logic              rd_data,
    input  logic              rd_status,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              dsr_n,
    input  logic              dcd_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              st_ready,
    output logic              st_frame_err,
    output logic              st_parity_err,
    output logic              st_overrun,
    output logic              st_dsr,
    output logic              st_dcd,
    output logic              st_dschg
);

    logic              rxd_s;
    logic              chr_done;
    logic [DATA_W-1:0] chr_data;
    logic              chr_fe;
    logic              chr_pe;
    logic [1:0]        modem_act;

    rx_sync_bits #(
        .WIDTH     (1),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_rxd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxd_s)
    );

    rx_bit_framer #(
        .DATA_W     (DATA_W),
        .MIN_BITS   (MIN_BITS),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .rx_tick     (rx_tick),
        .rxd_s       (rxd_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .chr_done    (chr_done),
        .chr_data    (chr_data),
        .chr_fe      (chr_fe),
        .chr_pe      (chr_pe)
    );

    rx_hold_status #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .chr_done      (chr_done),
        .chr_data      (chr_data),
        .chr_fe        (chr_fe),
        .chr_pe        (chr_pe),
        .rd_data       (rd_data),
        .err_clr       (err_clr),
        .rx_data       (rx_data),
        .st_ready      (st_ready),
        .st_frame_err  (st_frame_err),
        .st_parity_err (st_parity_err),
        .st_overrun    (st_overrun)
    );

    rx_modem_watch #(
        .PINS        (2),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_modem (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     ({dcd_n, dsr_n}),
        .rd_status (rd_status),
        .active    (modem_act),
        .changed   (st_dschg)
    );

    // Split modem status bits onto their ports
    always_comb begin
        st_dsr = modem_act[0];
        st_dcd = modem_act[1];
    end

endmodule

// File: rtl/rx_status_checker.sv
// Module: temporal checks on the receiver's status behaviour, bound to the top.
// Assumes: chr_done is the framer-to-status delivery pulse.
module rx_status_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic rd_data,
    input logic rd_status,
    input logic err_clr,
    input logic chr_done,
    input logic st_ready,
    input logic st_frame_err,
    input logic st_parity_err,
    input logic st_overrun,
    input logic st_dschg
);

    AST_DISABLE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !st_ready);                                              // R2
    AST_NO_DELIVERY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !chr_done);                                              // R2
    AST_DELIVERY_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        chr_done && rx_en |=> st_ready);                                    // R7
    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !chr_done |=> !st_ready);                                // R7
    AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        chr_done && rx_en && st_ready && !rd_data |=> st_overrun);          // R6
    AST_ERRCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !chr_done |=> !st_frame_err && !st_parity_err && !st_overrun); // R8
    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_frame_err && !err_clr |=> st_frame_err);                         // R8
    AST_PARITY_NEEDS_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_parity_err) |-> $past(chr_done));                          // R4
    AST_DSCHG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        st_dschg && !rd_status |=> st_dschg);                               // R11

endmodule

bind uart_rx_status rx_status_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .rd_data       (rd_data),
    .rd_status     (rd_status),
    .err_clr       (err_clr),
    .chr_done      (chr_done),
    .st_ready      (st_ready),
    .st_frame_err  (st_frame_err),
    .st_parity_err (st_parity_err),
    .st_overrun    (st_overrun),
    .st_dschg      (st_dschg)
);

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;

    localparam int BITCLK = 64;   // 16 ticks of 4 clocks each

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       err_clr = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       dsr_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic [7:0] rx_data;
    logic       st_ready, st_frame_err, st_parity_err, st_overrun;
    logic       st_dsr, st_dcd, st_dschg;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    uart_rx_status u_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd), .rx_en(rx_en),
        .err_clr(err_clr), .rd_data(rd_data), .rd_status(rd_status),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .dsr_n(dsr_n), .dcd_n(dcd_n), .rx_data(rx_data), .st_ready(st_ready),
        .st_frame_err(st_frame_err), .st_parity_err(st_parity_err),
        .st_overrun(st_overrun), .st_dsr(st_dsr), .st_dcd(st_dcd),
        .st_dschg(st_dschg)
    );

    always #2.5 clk = ~clk;

    // Tick generator: one pulse every 4 clocks
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            rx_tick = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    function automatic logic [7:0] len_mask(input int nb);
        return 8'((1 << nb) - 1);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input int nb, input logic odd);
        return (^(d & len_mask(nb))) ^ odd;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int nb = int'(cfg_len) + 5;
        @(negedge clk);
        rxd = 1'b0; wait_clk(BITCLK);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i]; wait_clk(BITCLK);
        end
        if (cfg_par_en) begin
            rxd = par_bit(d, nb, cfg_par_odd) ^ bad_par; wait_clk(BITCLK);
        end
        rxd = !bad_stop; wait_clk(BITCLK);
        rxd = 1'b1; wait_clk(2 * BITCLK);
    endtask

    task automatic pulse_read();
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
    endtask

    task automatic pulse_clear();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        wait_clk(4);
        // Reset state: R7, R10, R11
        check("R7 reset ready", int'(st_ready), 0);
        check("R8 reset errors", int'({st_frame_err, st_parity_err, st_overrun}), 0);
        check("R10 reset dsr/dcd", int'({st_dsr, st_dcd}), 0);
        check("R11 reset change", int'(st_dschg), 0);
        rst_n = 1'b1;
        rxd = 1'b0;
        wait_clk(8);

        // R1: line low across enable, back high just after an early mid-sample
        do @(posedge clk); while (!rx_tick);
        @(negedge clk); rx_en = 1'b1;
        repeat (36) @(posedge clk);
        @(negedge clk); rxd = 1'b1;
        wait_clk(40 * 4);
        check("R1 arming delay rejects early low", int'(st_ready), 0);

        // R3: 8-bit character
        send_frame(8'hA5, 0, 0);
        check("R3 data 8N", int'(rx_data), 8'hA5);
        check("R7 ready set", int'(st_ready), 1);
        pulse_read();
        check("R7 read clears ready", int'(st_ready), 0);

        // R3: every length with a full pattern
        for (int l = 0; l < 4; l++) begin
            cfg_len = 2'(l);
            send_frame(8'hB7, 0, 0);
            check("R3 length alignment", int'(rx_data), int'(8'hB7 & len_mask(l + 5)));
            pulse_read();
        end

        // R4: parity good and bad, even and odd
        cfg_len = 2'd3; cfg_par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            cfg_par_odd = m[0];
            send_frame(8'h3C, m[1], 0);
            check("R4 parity flag", int'(st_parity_err), m[1]);
            check("R4 parity data", int'(rx_data), 8'h3C);
            pulse_read(); pulse_clear();
        end
        cfg_par_en = 1'b0;

        // R9: short low pulse is noise
        @(negedge clk); rxd = 1'b0; wait_clk(16); rxd = 1'b1;
        wait_clk(3 * BITCLK);
        check("R9 glitch rejected", int'(st_ready), 0);
        send_frame(8'h5A, 0, 0);
        check("R9 search resumes", int'(rx_data), 8'h5A);
        pulse_read();

        // R5: low stop bit, long low hold, then recovery
        @(negedge clk); rxd = 1'b0; wait_clk(BITCLK);
        for (int i = 0; i < 8; i++) begin rxd = 1'(8'h81 >> i); wait_clk(BITCLK); end
        rxd = 1'b0; wait_clk(3 * BITCLK);
        rxd = 1'b1; wait_clk(2 * BITCLK);
        check("R5 framing flag", int'(st_frame_err), 1);
        check("R5 character delivered", int'(rx_data), 8'h81);
        pulse_read();
        send_frame(8'h42, 0, 0);
        check("R5 waits for high then resumes", int'(rx_data), 8'h42);
        check("R8 framing sticky after read", int'(st_frame_err), 1);
        pulse_read();
        pulse_clear();
        check("R8 clear pulse", int'(st_frame_err), 0);

        // R6: overrun
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0);
        check("R6 overrun flag", int'(st_overrun), 1);
        check("R6 newest kept", int'(rx_data), 8'h22);
        pulse_read();
        check("R8 overrun sticky", int'(st_overrun), 1);
        pulse_clear();
        check("R8 overrun cleared", int'(st_overrun), 0);

        // R2: disable mid-character
        send_frame(8'h77, 0, 0);
        @(negedge clk); rxd = 1'b0; wait_clk(4 * BITCLK);
        rx_en = 1'b0;
        @(negedge clk);
        check("R2 disable drops ready", int'(st_ready), 0);
        rxd = 1'b1; wait_clk(8 * BITCLK);
        check("R2 nothing delivered", int'(st_ready), 0);
        rx_en = 1'b1; wait_clk(20);
        send_frame(8'h3C, 0, 0);
        check("R2 clean restart data", int'(rx_data), 8'h3C);
        check("R2 no overrun", int'(st_overrun), 0);
        pulse_read();

        // R10 / R11: modem pins
        dsr_n = 1'b0; wait_clk(4);
        check("R10 dsr active", int'(st_dsr), 1);
        check("R10 dcd idle", int'(st_dcd), 0);
        check("R11 change set", int'(st_dschg), 1);
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
        check("R11 status read clears", int'(st_dschg), 0);
        dcd_n = 1'b0; dsr_n = 1'b1; wait_clk(4);
        check("R10 dcd active", int'({st_dsr, st_dcd}), 2'b01);
        check("R11 change again", int'(st_dschg), 1);
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
        wait_clk(4);
        check("R11 stays clear", int'(st_dschg), 0);

        // Random frames: R3, R4, R5
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d = 8'($urandom);
            bit bp = ($urandom % 5) == 0;
            bit bs = ($urandom % 6) == 0;
            cfg_len = 2'($urandom % 4);
            cfg_par_en = 1'($urandom % 2);
            cfg_par_odd = 1'($urandom % 2);
            send_frame(d, bp, bs);
            check("R3 random data", int'(rx_data), int'(d & len_mask(int'(cfg_len) + 5)));
            check("R4 random parity", int'(st_parity_err), int'(cfg_par_en & bp));
            check("R5 random framing", int'(st_frame_err), int'(bs));
            pulse_read(); pulse_clear();
        end

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule